// File: doc/BRIEF.md
# Packed Lane Sign-Apply Unit

This block is a SIMD datapath stage. It takes two equal-width operand vectors: a data vector and a control vector. Both are split into signed lanes of a size chosen at run time. For each lane, the sign and zero test of the control lane picks one of three actions on the matching data lane: negate it (two's complement), force it to zero, or pass it through unchanged. Each lane is handled on its own and by the same rule.

A vector-width select chooses between a 64-bit operation and a 128-bit operation. In the 64-bit case only the low half is processed and the high half of the result is zero. A single register stage with input and output valid strobes gives a fixed latency of one clock. The unit fits into an execution pipeline slot that has already fetched and decoded its operands.

Top module: `psa_sign_unit`

## Requirements
- R1: When a control lane is negative as a signed integer (its top bit is 1), the result lane is the two's-complement negation of the data lane, taken modulo the lane width.
- R2: When a control lane is all zeros, the result lane is all zeros, whatever the data lane holds.
- R3: When a control lane is strictly positive (top bit 0 and not zero), the result lane equals the data lane.
- R4: `lane_sel` encodes the lane size as 2'b00 = 8-bit, 2'b01 = 16-bit and 2'b10 = 32-bit. The code 2'b11 is reserved and yields an all-zero result.
- R5: With `wide_sel` = 1, all 128 bits are processed (16, 8 or 4 lanes). With `wide_sel` = 0, only bits [63:0] are processed (8, 4 or 2 lanes) and bits [127:64] of the result are zero.
- R6: Negating the most negative lane value (only the top lane bit set) gives the same value back, with no saturation.
- R7: The result register loads only in a cycle where `in_valid` is high. Otherwise `out_result` keeps its value.
- R8: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-high `rst` clears `out_valid` and `out_result`.
- R9: Lanes are independent: the result of each lane depends only on its own data and control lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| in_data | input | 128 | Data vector whose lanes are negated, zeroed or kept |
| in_ctrl | input | 128 | Control vector whose lane signs pick the action |
| lane_sel | input | 2 | Lane size code (see R4) |
| wide_sel | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_result | output | 128 | Registered result vector |

## Verification
The assertions assume that `lane_sel`, `wide_sel` and both operand vectors are driven to known values in every cycle where `in_valid` is high. They also assume that `rst` is a clean level sampled at the clock. The bench drives every input at the falling edge and keeps all of them defined, including in idle cycles. Random operands are built so that zero, positive and negative control lanes all occur at every lane size. Directed cases then cover the reserved size code, the 64-bit mode and the most negative lane values.

// File: rtl/psa_pkg.sv
package psa_pkg;

  typedef enum logic [1:0] {
    LS_B8   = 2'b00,
    LS_B16  = 2'b01,
    LS_B32  = 2'b10,
    LS_RSVD = 2'b11
  } lane_size_e;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_ZERO = 2'b01,
    ACT_NEG  = 2'b10
  } lane_act_e;

endpackage

// File: rtl/psa_lane_op.sv
module psa_lane_op #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] ctrl_i,
  output logic [W-1:0] res_o
);
  import psa_pkg::*;

  lane_act_e act;

  function automatic lane_act_e pick_act(input logic [W-1:0] c);
    if (c == '0)       return ACT_ZERO;
    else if (c[W-1])   return ACT_NEG;
    else               return ACT_KEEP;
  endfunction

  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] d);
    return (~d) + W'(1);
  endfunction

  always_comb begin
    act = pick_act(ctrl_i);
    unique case (act)
      ACT_ZERO: res_o = '0;
      ACT_NEG:  res_o = twos_neg(data_i);
      default:  res_o = data_i;
    endcase
  end

endmodule

// File: rtl/psa_lane_bank.sv
module psa_lane_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] data_i,
  input  logic [VEC_W-1:0] ctrl_i,
  output logic [VEC_W-1:0] res_o
);
  localparam int LANES = VEC_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psa_lane_op #(.W(LANE_W)) u_lane (
      .data_i (data_i[g*LANE_W +: LANE_W]),
      .ctrl_i (ctrl_i[g*LANE_W +: LANE_W]),
      .res_o  (res_o[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/psa_select.sv
module psa_select #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] res_b8_i,
  input  logic [VEC_W-1:0] res_b16_i,
  input  logic [VEC_W-1:0] res_b32_i,
  input  logic [1:0]       lane_sel_i,
  input  logic             wide_i,
  output logic [VEC_W-1:0] res_o
);
  import psa_pkg::*;

  localparam int HALF = VEC_W / 2;

  logic [VEC_W-1:0] by_size;

  always_comb begin
    unique case (lane_size_e'(lane_sel_i))
      LS_B8:   by_size = res_b8_i;
      LS_B16:  by_size = res_b16_i;
      LS_B32:  by_size = res_b32_i;
      default: by_size = '0;
    endcase
    res_o = by_size;
    if (!wide_i) res_o[VEC_W-1:HALF] = '0;
  end

endmodule

// File: rtl/psa_sign_unit.sv
module psa_sign_unit #(
  parameter int VEC_W = 128,
  parameter int B8_W  = 8,
  parameter int B16_W = 16,
  parameter int B32_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_data,
  input  logic [VEC_W-1:0] in_ctrl,
  input  logic [1:0]       lane_sel,
  input  logic             wide_sel,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_result
);

  logic [VEC_W-1:0] res_b8, res_b16, res_b32;
  logic [VEC_W-1:0] comb_result;
  logic             load_en;

  psa_lane_bank #(.VEC_W(VEC_W), .LANE_W(B8_W)) u_bank_b8 (
    .data_i (in_data), .ctrl_i (in_ctrl), .res_o (res_b8)
  );
  psa_lane_bank #(.VEC_W(VEC_W), .LANE_W(B16_W)) u_bank_b16 (
    .data_i (in_data), .ctrl_i (in_ctrl), .res_o (res_b16)
  );
  psa_lane_bank #(.VEC_W(VEC_W), .LANE_W(B32_W)) u_bank_b32 (
    .data_i (in_data), .ctrl_i (in_ctrl), .res_o (res_b32)
  );

  psa_select #(.VEC_W(VEC_W)) u_select (
    .res_b8_i   (res_b8),
    .res_b16_i  (res_b16),
    .res_b32_i  (res_b32),
    .lane_sel_i (lane_sel),
    .wide_i     (wide_sel),
    .res_o      (comb_result)
  );

  assign load_en = in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (load_en) out_result <= comb_result;
    end
  end

endmodule

// File: rtl/psa_sign_unit_chk.sv
module psa_sign_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [VEC_W-1:0] in_ctrl,
  input logic [1:0]       lane_sel,
  input logic             wide_sel,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_result
);
  localparam int HALF = VEC_W / 2;

  a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid) |=> out_valid);

  a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !in_valid) |=> $stable(out_result));

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && !wide_sel) |=> (out_result[VEC_W-1:HALF] == '0));

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && lane_sel == 2'b11) |=> (out_result == '0));

  a_r2_zero_ctrl: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_valid && in_ctrl == '0) |=> (out_result == '0));

endmodule

bind psa_sign_unit psa_sign_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ctrl    (in_ctrl),
  .lane_sel   (lane_sel),
  .wide_sel   (wide_sel),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/psa_sign_unit_tb.sv
`timescale 1ns/1ps
module psa_sign_unit_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] in_data, in_ctrl;
  logic [1:0]   lane_sel;
  logic         wide_sel;
  logic         out_valid;
  logic [127:0] out_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  psa_sign_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .lane_sel(lane_sel), .wide_sel(wide_sel),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] c,
                                         input logic [1:0] sel, input logic wide);
    logic [127:0] r, mask, dl, cl;
    int lw, n;
    r = '0;
    if (sel == 2'b11) return r;
    lw = 8 << sel;
    n  = (wide ? 128 : 64) / lw;
    mask = (128'd1 << lw) - 128'd1;
    for (int i = 0; i < n; i++) begin
      dl = (d >> (i * lw)) & mask;
      cl = (c >> (i * lw)) & mask;
      if (cl == '0)                dl = '0;
      else if (cl[lw-1])           dl = ((~dl) + 128'd1) & mask;
      r = r | (dl << (i * lw));
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] d, input logic [127:0] c,
                       input logic [1:0] sel, input logic wide, input string tag);
    in_valid = 1'b1; in_data = d; in_ctrl = c; lane_sel = sel; wide_sel = wide;
    @(negedge clk);
    check({tag, " valid"}, {127'd0, out_valid}, 128'd1);
    check(tag, out_result, model(d, c, sel, wide));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] rnd_ctrl();
    logic [127:0] c;
    c = rnd128();
    for (int i = 0; i < 16; i++) if ($urandom % 5 == 0) c[i*8 +: 8] = 8'h00;
    for (int i = 0; i < 8; i++)  if ($urandom % 5 == 0) c[i*16 +: 16] = 16'h0000;
    for (int i = 0; i < 4; i++)  if ($urandom % 5 == 0) c[i*32 +: 32] = 32'h0;
    for (int i = 0; i < 4; i++)  if ($urandom % 6 == 0) c[i*32 +: 32] = 32'h1;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b1; in_data = '1; in_ctrl = '1; lane_sel = 2'b00; wide_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset clears output
    check("R8 reset valid", {127'd0, out_valid}, 128'd0);
    check("R8 reset result", out_result, 128'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R8 idle valid low", {127'd0, out_valid}, 128'd0);

    // R1 R2 R3 per lane size: mixed signs
    apply({16{8'h05}}, {4{8'h80, 8'h00, 8'h7f, 8'h01}}, 2'b00, 1'b1, "R1 R2 R3 b8 mixed");
    apply({8{16'h1234}}, {2{16'hffff, 16'h0000, 16'h0001, 16'h8000}}, 2'b01, 1'b1, "R1 R2 R3 b16 mixed");
    apply({4{32'hdeadbeef}}, {32'h80000000, 32'h0, 32'h7fffffff, 32'hffffffff}, 2'b10, 1'b1, "R1 R2 R3 b32 mixed");
    // R2 all-zero control
    apply(rnd128(), 128'd0, 2'b01, 1'b1, "R2 zero ctrl");
    // R3 all positive control
    apply(128'h0123456789abcdef_fedcba9876543210, {16{8'h11}}, 2'b00, 1'b1, "R3 keep");
    // R6 most negative wraps
    apply({16{8'h80}}, '1, 2'b00, 1'b1, "R6 b8 wrap");
    apply({8{16'h8000}}, '1, 2'b01, 1'b1, "R6 b16 wrap");
    apply({4{32'h80000000}}, '1, 2'b10, 1'b1, "R6 b32 wrap");
    // R4 reserved code
    apply(rnd128(), '1, 2'b11, 1'b1, "R4 reserved");
    // R5 narrow mode
    apply('1, {64'h0000000100000001, 64'hffffffffffffffff}, 2'b10, 1'b0, "R5 narrow b32");
    apply(rnd128(), rnd_ctrl(), 2'b00, 1'b0, "R5 narrow b8");
    // R9 lane independence: one lane negative, neighbours positive
    apply({16{8'h3c}}, {{7{8'h01}}, 8'hff, {8{8'h01}}}, 2'b00, 1'b1, "R9 single lane");

    // R7 hold while idle, R8 valid drops
    held = out_result;
    in_valid = 1'b0; in_data = rnd128(); in_ctrl = rnd_ctrl(); lane_sel = 2'b01;
    @(negedge clk);
    check("R8 valid follows low", {127'd0, out_valid}, 128'd0);
    check("R7 hold", out_result, held);
    @(negedge clk);
    check("R7 hold second", out_result, held);

    // random
    for (int k = 0; k < 400; k++) begin
      logic [1:0] s;
      s = 2'($urandom % 4);
      if (s == 2'b11 && ($urandom % 4 != 0)) s = 2'b00;
      apply(rnd128(), rnd_ctrl(), s, 1'($urandom % 2), "R1 R2 R3 R5 R9 random");
      if ($urandom % 8 == 0) begin
        held = out_result;
        in_valid = 1'b0; in_data = rnd128();
        @(negedge clk);
        check("R7 random hold", out_result, held);
      end
    end

    // R8 reset mid-stream
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R8 reset clears", out_result, 128'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule